// File: doc/BRIEF.md
# Serially Loaded Cartridge Bank Mapper

This block sits between a cartridge port and a parallel flash device and turns each cartridge access into a flash address and a set of flash strobes. The cartridge sees a 32 KB window on its fifteen address lines. The lower 16 KB of that window (top address line low) is mapped through a software-chosen 7-bit bank. The upper 16 KB (top address line high) always lands on the last bank, where all seven bank bits are ones. The flash address is the bank bits placed above the fourteen low cartridge address bits, which gives a 2 MB flash space. The data bus passes beside the block and is not handled here.

The bank number is not written as a parallel register. Software toggles three general-purpose port pins instead. One pin is serial data, one is a shift clock and one is a latch. Each rising shift-clock edge pushes the data bit into the least significant end of a 7-bit chain, so a bank value is sent most significant bit first. A rising latch edge copies the chain into the bank register that drives the flash address. All three pins are asynchronous to the block clock and are synchronized before their edges are detected. The address and strobe outputs are registered one block-clock cycle after the bus inputs.

Top module: `cart_bank_mapper`

## Requirements
- R1: A synchronous active-high reset drives `flash_addr` to 0 and `flash_ce_n`, `flash_oe_n` and `flash_we_n` to 1. It also clears the bank register and the shift chain, so a latch pulse given straight after reset, with no shifts, selects bank 0.
- R2: `flash_ce_n` equals the value `cart_sel_n` had one clock earlier.
- R3: `flash_oe_n` equals the OR of `cart_sel_n` and `rd_n` from one clock earlier, and `flash_we_n` equals the OR of `cart_sel_n` and `wr_n` from one clock earlier. Output-enable is therefore never low while chip-enable is high.
- R4: When `cart_addr[14]` is 0, `flash_addr` one clock later is {bank[6:0], cart_addr[13:0]}, with the bank in bits 20..14.
- R5: When `cart_addr[14]` is 1, `flash_addr[20:14]` one clock later is 7'h7F and `flash_addr[13:0]` equals `cart_addr[13:0]`, whatever the bank holds.
- R6: Each rising edge of `ser_clk` shifts the synchronized level of `ser_data` into chain bit 0 and moves every other chain bit one place toward bit 6. Seven shifts therefore load a value MSB first.
- R7: A rising edge of `ser_latch` copies the whole 7-bit chain into the bank register, and the new bank shows in the lower-window address within four clocks of the pin edge.
- R8: Shift-clock edges that are not followed by a latch edge leave the bank register, and so the flash address, unchanged.
- R9: When shift-clock and latch edges are detected in the same clock, the bank takes the chain contents from before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cart_addr | input | 15 | Cartridge address lines 0..14 |
| cart_sel_n | input | 1 | Cartridge select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ser_data | input | 1 | Serial bank data pin (asynchronous) |
| ser_clk | input | 1 | Serial shift clock pin (asynchronous) |
| ser_latch | input | 1 | Bank latch pin (asynchronous) |
| flash_addr | output | 21 | Registered flash address |
| flash_ce_n | output | 1 | Registered flash chip-enable, active low |
| flash_oe_n | output | 1 | Registered flash output-enable, active low |
| flash_we_n | output | 1 | Registered flash write-enable, active low |

## Verification
The shift and the latch can land in the same clock when software raises both pins together. In that case it is unclear whether the bank gets the chain before or after the shift. The bench provokes this by first loading a known pattern into the chain, then raising the shift clock and the latch in one step with a chosen data bit. It then requires that the lower-window address shows the pattern from before the shift. A second latch pulse alone must then show the shifted pattern, which proves the shift was not lost.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // Index of each serial control pin inside the synchronized pin vector
  localparam int PIN_DATA  = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_LATCH = 2;
  localparam int PIN_COUNT = 3;

  // Edge detection is wanted on every pin except the data line
  function automatic bit pin_wants_edge(input int idx);
    return idx != PIN_DATA;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES      = 2,
  parameter bit DETECT_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic sig
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], pin};
  end

  generate
    if (DETECT_RISE) begin : g_rise
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sr[STAGES-1];
      end
      assign sig = sr[STAGES-1] & ~prev;
    end else begin : g_level
      assign sig = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bank_shifter.sv
module bank_shifter #(
  parameter int BANK_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              latch_en,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      bank  <= '0;
    end else begin
      if (shift_en) chain <= {chain[BANK_W-2:0], shift_bit};
      // latch samples the chain as it stood before this cycle's shift
      if (latch_en) bank <= chain;
    end
  end
endmodule

// File: rtl/addr_map.sv
module addr_map #(
  parameter int CART_AW = 15,
  parameter int BANK_W  = 7,
  localparam int WIN_AW   = CART_AW - 1,
  localparam int FLASH_AW = BANK_W + WIN_AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CART_AW-1:0]  cart_addr,
  input  logic                cart_sel_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [BANK_W-1:0]   bank,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_ce_n,
  output logic                flash_oe_n,
  output logic                flash_we_n
);
  logic [BANK_W-1:0] upper;

  always_comb begin
    if (cart_addr[CART_AW-1]) upper = '1;
    else                      upper = bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_addr <= '0;
      flash_ce_n <= 1'b1;
      flash_oe_n <= 1'b1;
      flash_we_n <= 1'b1;
    end else begin
      flash_addr <= {upper, cart_addr[WIN_AW-1:0]};
      flash_ce_n <= cart_sel_n;
      flash_oe_n <= cart_sel_n | rd_n;
      flash_we_n <= cart_sel_n | wr_n;
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int CART_AW     = 15,
  parameter int BANK_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int WIN_AW   = CART_AW - 1,
  localparam int FLASH_AW = BANK_W + WIN_AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CART_AW-1:0]  cart_addr,
  input  logic                cart_sel_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                ser_data,
  input  logic                ser_clk,
  input  logic                ser_latch,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_ce_n,
  output logic                flash_oe_n,
  output logic                flash_we_n
);
  import mapper_pkg::*;

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_sync;
  logic [BANK_W-1:0]    bank_q;
  logic                 latch_rise;

  assign pins_raw[PIN_DATA]  = ser_data;
  assign pins_raw[PIN_SCLK]  = ser_clk;
  assign pins_raw[PIN_LATCH] = ser_latch;

  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
      pin_sync #(
        .STAGES     (SYNC_STAGES),
        .DETECT_RISE(pin_wants_edge(i))
      ) u_sync (
        .clk(clk),
        .rst(rst),
        .pin(pins_raw[i]),
        .sig(pins_sync[i])
      );
    end
  endgenerate

  assign latch_rise = pins_sync[PIN_LATCH];

  bank_shifter #(.BANK_W(BANK_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (pins_sync[PIN_SCLK]),
    .shift_bit(pins_sync[PIN_DATA]),
    .latch_en (latch_rise),
    .bank     (bank_q)
  );

  addr_map #(.CART_AW(CART_AW), .BANK_W(BANK_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .cart_addr (cart_addr),
    .cart_sel_n(cart_sel_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bank      (bank_q),
    .flash_addr(flash_addr),
    .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n)
  );
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int CART_AW = 15,
  parameter int BANK_W  = 7,
  localparam int WIN_AW   = CART_AW - 1,
  localparam int FLASH_AW = BANK_W + WIN_AW
) (
  input logic                clk,
  input logic                rst,
  input logic [CART_AW-1:0]  cart_addr,
  input logic                cart_sel_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic [FLASH_AW-1:0] flash_addr,
  input logic                flash_ce_n,
  input logic                flash_oe_n,
  input logic                flash_we_n,
  input logic [BANK_W-1:0]   bank_q,
  input logic                latch_rise
);
  assert_ce_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flash_ce_n == $past(cart_sel_n));

  assert_oe_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flash_oe_n == ($past(cart_sel_n) | $past(rd_n)));

  assert_we_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flash_we_n == ($past(cart_sel_n) | $past(wr_n)));

  assert_oe_needs_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> !flash_ce_n);

  assert_lower_bank_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cart_addr[CART_AW-1]))
      |-> flash_addr[FLASH_AW-1:WIN_AW] == $past(bank_q));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cart_addr[CART_AW-1]))
      |-> flash_addr[FLASH_AW-1:WIN_AW] == {BANK_W{1'b1}});

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flash_addr[WIN_AW-1:0] == $past(cart_addr[WIN_AW-1:0]));

  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(latch_rise)) |-> bank_q == $past(bank_q));
endmodule

bind cart_bank_mapper mapper_checker #(.CART_AW(CART_AW), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cart_addr (cart_addr),
  .cart_sel_n(cart_sel_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .flash_addr(flash_addr),
  .flash_ce_n(flash_ce_n),
  .flash_oe_n(flash_oe_n),
  .flash_we_n(flash_we_n),
  .bank_q    (bank_q),
  .latch_rise(latch_rise)
);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] cart_addr;
  logic        cart_sel_n, rd_n, wr_n;
  logic        ser_data, ser_clk, ser_latch;
  logic [20:0] flash_addr;
  logic        flash_ce_n, flash_oe_n, flash_we_n;

  int n_chk = 0;
  int n_err = 0;
  logic [6:0] m_chain;
  logic [6:0] m_bank;

  always #5 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst(rst), .cart_addr(cart_addr), .cart_sel_n(cart_sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

  function automatic logic [20:0] exp_addr(input logic [14:0] a, input logic [6:0] b);
    return {(a[14] ? 7'h7F : b), a[13:0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [14:0] a, input logic s, input logic r, input logic w);
    cart_addr = a; cart_sel_n = s; rd_n = r; wr_n = w;
    tick(1);
  endtask

  task automatic check_bus(input string req);
    check({req, " addr"}, 32'(flash_addr), 32'(exp_addr(cart_addr, m_bank)));
    check({req, " ce"}, 32'(flash_ce_n), 32'(cart_sel_n));
    check({req, " oe"}, 32'(flash_oe_n), 32'(cart_sel_n | rd_n));
    check({req, " we"}, 32'(flash_we_n), 32'(cart_sel_n | wr_n));
  endtask

  task automatic shift_bit(input logic d);
    ser_data = d; tick(4);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(4);
    m_chain = {m_chain[5:0], d};
  endtask

  task automatic latch_pulse();
    ser_latch = 1'b1; tick(4);
    ser_latch = 1'b0; tick(4);
    m_bank = m_chain;
  endtask

  task automatic load_bank(input logic [6:0] v);
    for (int i = 6; i >= 0; i--) shift_bit(v[i]);
    latch_pulse();
  endtask

  initial begin
    void'($urandom(32'd20251));
    rst = 1'b1; cart_addr = '0; cart_sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ser_data = 1'b0; ser_clk = 1'b0; ser_latch = 1'b0;
    m_chain = '0; m_bank = '0;
    tick(4);
    // R1: reset values at the ports
    check("R1 addr", 32'(flash_addr), 32'h0);
    check("R1 ce", 32'(flash_ce_n), 32'h1);
    check("R1 oe", 32'(flash_oe_n), 32'h1);
    check("R1 we", 32'(flash_we_n), 32'h1);
    rst = 1'b0; tick(2);

    // R4 bank 0 after reset, R2/R3 read strobe
    bus(15'h1234, 1'b0, 1'b0, 1'b1); check_bus("R4 R2 R3 lower read");
    bus(15'h0ABC, 1'b1, 1'b0, 1'b0); check_bus("R2 R3 deselected strobes");

    // R6 R7: load a bank, observe lower window
    load_bank(7'h55);
    bus(15'h0100, 1'b0, 1'b1, 1'b0); check_bus("R6 R7 lower write");
    check("R7 bank bits", 32'(flash_addr[20:14]), 32'h55);

    // R5: upper window ignores bank
    bus(15'h7FFF, 1'b0, 1'b0, 1'b1); check_bus("R5 upper top");
    check("R5 upper bits", 32'(flash_addr[20:14]), 32'h7F);
    bus(15'h4000, 1'b0, 1'b0, 1'b1); check_bus("R5 upper base");

    // R8: shifting without latch leaves address alone
    bus(15'h2001, 1'b0, 1'b0, 1'b1);
    shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    check("R8 bank unchanged", 32'(flash_addr[20:14]), 32'h55);
    check_bus("R8 after shifts");

    // R9: shift and latch in the same cycle
    for (int i = 6; i >= 0; i--) shift_bit(7'h2C >> i);
    ser_data = 1'b1; tick(4);
    ser_clk = 1'b1; ser_latch = 1'b1; tick(4);
    ser_clk = 1'b0; ser_latch = 1'b0; tick(4);
    m_bank = m_chain; m_chain = {m_chain[5:0], 1'b1};
    check("R9 pre-shift latched", 32'(flash_addr[20:14]), 32'h2C);
    latch_pulse();
    check("R9 shift kept", 32'(flash_addr[20:14]), 32'h59);

    // R1: reset clears the chain too
    for (int i = 0; i < 7; i++) shift_bit(1'b1);
    rst = 1'b1; tick(2); rst = 1'b0; tick(2);
    m_chain = '0; m_bank = '0;
    latch_pulse();
    check("R1 chain cleared", 32'(flash_addr[20:14]), 32'h0);

    // random mix of bank loads and bus cycles
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(3) == 0) load_bank(7'($urandom));
      bus(15'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      check_bus("R2 R3 R4 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule